// File: doc/BRIEF.md
# Bit-Count and Byte-Manipulation Unit

A combinational single-operand unit for a 64-bit integer datapath. One operand, a 4-bit operation code and a word-mode flag go in. A 64-bit result and an illegal-operation flag come out in the same cycle. The unit counts leading zeros, trailing zeros and set bits, in full-width form or in a 32-bit word form. It also sign-extends a byte or a halfword, zero-extends a halfword, turns each non-zero byte into all-ones, and reverses the byte order of the whole operand.

Two enable inputs say which operation groups the surrounding core allows. When the selected code is unused, or its group is not enabled, the unit raises the illegal flag and drives a zero result. Instruction decode, register access and pipelining are left to the surrounding core.

Top module: `bitcount_byte_unit`

## Requirements
- R1: Code 0 with word mode low returns the number of leading zeros of the full operand, and 64 when the operand is zero.
- R2: Code 0 with word mode high returns the number of leading zeros within bits 31:0 only, and 32 when those bits are zero. Bits 63:32 do not affect the result.
- R3: Code 1 returns the number of trailing zeros. With word mode low it counts over all 64 bits and returns 64 for a zero operand. With word mode high it counts over bits 31:0 and returns 32 when they are zero.
- R4: Code 2 returns the number of set bits: over all 64 bits with word mode low, over bits 31:0 only with word mode high. Every count result is right-aligned, with all upper result bits zero.
- R5: Code 3 sign-extends bit 7 over bits 63:8 and keeps bits 7:0. Code 4 sign-extends bit 15 over bits 63:16 and keeps bits 15:0.
- R6: Code 5 keeps bits 15:0 and clears bits 63:16.
- R7: Code 6 sets each result byte to 0xFF when the matching operand byte is non-zero, and to 0x00 otherwise.
- R8: Code 7 reverses all eight bytes: result byte k equals operand byte 7-k.
- R9: For codes 3 to 7, the word-mode flag has no effect on the result.
- R10: Codes 0 to 6 are legal only when the base enable is high. Code 7 is legal when either the base enable or the crypto enable is high. A disabled code raises the illegal flag and returns zero.
- R11: Codes 8 to 15 always raise the illegal flag and return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (0 to 7 defined) |
| word_i | input | 1 | Selects the 32-bit form of the count operations |
| operand_i | input | 64 | Source operand |
| en_base_i | input | 1 | Enables the base bit-manipulation group |
| en_crypto_i | input | 1 | Enables the crypto group (byte reversal only) |
| result_o | output | 64 | Operation result |
| illegal_o | output | 1 | Selected code is unused or not enabled |

## Verification
The bench builds the unit with its default parameter, a 64-bit datapath and therefore a 32-bit word form. At this width the counters reach both of their saturated values, 64 and 32. The two sentinel bits that cap the word counts sit exactly at the half boundary, so single-bit operands at bits 31 and 32 test whether the word forms ignore the upper half. All eight byte lanes take part in the reversal and the per-byte combine, so corner operands that fill only one lane show where a lane has been miswired.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

    typedef enum logic [3:0] {
        OP_LZC   = 4'd0,
        OP_TZC   = 4'd1,
        OP_POPC  = 4'd2,
        OP_SXB   = 4'd3,
        OP_SXH   = 4'd4,
        OP_ZXH   = 4'd5,
        OP_BYTOR = 4'd6,
        OP_BSWAP = 4'd7
    } bcu_op_e;

    typedef struct packed {
        logic illegal;
        logic is_count;
    } bcu_dec_t;

    function automatic bcu_dec_t bcu_decode(logic [3:0] code, logic base_en, logic crypto_en);
        bcu_dec_t d;
        d.is_count = (code <= 4'd2);
        if (code > 4'd7)
            d.illegal = 1'b1;
        else if (code == OP_BSWAP)
            d.illegal = !(base_en || crypto_en);
        else
            d.illegal = !base_en;
        return d;
    endfunction

endpackage

// File: rtl/bcu_trail_count.sv
module bcu_trail_count #(
    parameter int W = 64,
    localparam int CW = $clog2(W) + 1,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);
    always_comb begin
        cnt_o = CW'(W);
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) cnt_o = CW'(i);
        end
    end

    always_comb begin
        AST_COUNT_BOUND: assert (cnt_o <= CW'(W)) else $error("count out of range"); // R3
        if (cnt_o < CW'(W)) begin
            AST_FIRST_ONE: assert (vec_i[cnt_o[IW-1:0]]) else $error("count not at a set bit"); // R3
        end
    end
endmodule

// File: rtl/bcu_popcount.sv
module bcu_popcount #(
    parameter int W = 64,
    localparam int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);
    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < W; i++) begin
            cnt_o = cnt_o + CW'(vec_i[i]);
        end
    end

    always_comb begin
        AST_POP_MATCH: assert (32'(cnt_o) == 32'($countones(vec_i))) else $error("population mismatch"); // R4
    end
endmodule

// File: rtl/bcu_byte_ops.sv
module bcu_byte_ops #(
    parameter int XLEN = 64,
    localparam int NB = XLEN / 8
) (
    input  logic [XLEN-1:0] opd_i,
    output logic [XLEN-1:0] sxb_o,
    output logic [XLEN-1:0] sxh_o,
    output logic [XLEN-1:0] zxh_o,
    output logic [XLEN-1:0] bytor_o,
    output logic [XLEN-1:0] bswap_o
);
    assign sxb_o = {{(XLEN-8){opd_i[7]}}, opd_i[7:0]};
    assign sxh_o = {{(XLEN-16){opd_i[15]}}, opd_i[15:0]};
    assign zxh_o = {{(XLEN-16){1'b0}}, opd_i[15:0]};

    for (genvar k = 0; k < NB; k++) begin : g_lane
        assign bytor_o[8*k +: 8] = {8{|opd_i[8*k +: 8]}};
        assign bswap_o[8*k +: 8] = opd_i[8*(NB-1-k) +: 8];
    end

    always_comb begin
        for (int k = 0; k < NB; k++) begin
            AST_BYTOR_LANE: assert (bytor_o[8*k +: 8] == 8'h00 || bytor_o[8*k +: 8] == 8'hFF) else $error("lane not uniform"); // R7
        end
        AST_BSWAP_POP: assert ($countones(bswap_o) == $countones(opd_i)) else $error("swap lost bits"); // R8
    end
endmodule

// File: rtl/bitcount_byte_unit.sv
module bitcount_byte_unit
    import bcu_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int WORD = XLEN / 2,
    localparam int CW = $clog2(XLEN) + 1
) (
    input  logic [3:0]      op_i,
    input  logic            word_i,
    input  logic [XLEN-1:0] operand_i,
    input  logic            en_base_i,
    input  logic            en_crypto_i,
    output logic [XLEN-1:0] result_o,
    output logic            illegal_o
);
    bcu_dec_t        dec;
    logic [XLEN-1:0] lz_src, lz_rev, tz_src, pop_src;
    logic [CW-1:0]   lz_cnt, tz_cnt, pop_cnt;
    logic [XLEN-1:0] sxb, sxh, zxh, bytor, bswap;

    assign dec = bcu_decode(op_i, en_base_i, en_crypto_i);

    // Sentinel bit at the half boundary caps word counts at WORD.
    assign lz_src  = word_i ? {operand_i[WORD-1:0], 1'b1, {(WORD-1){1'b0}}} : operand_i;
    assign tz_src  = word_i ? {{(WORD-1){1'b0}}, 1'b1, operand_i[WORD-1:0]} : operand_i;
    assign pop_src = word_i ? {{WORD{1'b0}}, operand_i[WORD-1:0]} : operand_i;

    for (genvar i = 0; i < XLEN; i++) begin : g_rev
        assign lz_rev[i] = lz_src[XLEN-1-i];
    end

    bcu_trail_count #(.W(XLEN)) i_lead (.vec_i(lz_rev), .cnt_o(lz_cnt));
    bcu_trail_count #(.W(XLEN)) i_trail (.vec_i(tz_src), .cnt_o(tz_cnt));
    bcu_popcount    #(.W(XLEN)) i_pop (.vec_i(pop_src), .cnt_o(pop_cnt));

    bcu_byte_ops #(.XLEN(XLEN)) i_bytes (
        .opd_i  (operand_i),
        .sxb_o  (sxb),
        .sxh_o  (sxh),
        .zxh_o  (zxh),
        .bytor_o(bytor),
        .bswap_o(bswap)
    );

    always_comb begin
        result_o = '0;
        if (!dec.illegal) begin
            case (op_i)
                OP_LZC:   result_o = {{(XLEN-CW){1'b0}}, lz_cnt};
                OP_TZC:   result_o = {{(XLEN-CW){1'b0}}, tz_cnt};
                OP_POPC:  result_o = {{(XLEN-CW){1'b0}}, pop_cnt};
                OP_SXB:   result_o = sxb;
                OP_SXH:   result_o = sxh;
                OP_ZXH:   result_o = zxh;
                OP_BYTOR: result_o = bytor;
                OP_BSWAP: result_o = bswap;
                default:  result_o = '0;
            endcase
        end
    end

    assign illegal_o = dec.illegal;

    always_comb begin
        AST_ILLEGAL_ZERO: assert (!illegal_o || result_o == '0) else $error("illegal result not zero"); // R10
        AST_HIGH_CODE: assert (op_i < 4'd8 || illegal_o) else $error("unused code accepted"); // R11
        if (!illegal_o && dec.is_count) begin
            AST_COUNT_ALIGN: assert (result_o <= XLEN'(XLEN)) else $error("count not right-aligned"); // R4
            if (word_i) begin
                AST_WORD_CAP: assert (result_o <= XLEN'(WORD)) else $error("word count above cap"); // R2
            end
        end
    end
endmodule

// File: tb/test_bitcount_byte_unit.sv
module test_bitcount_byte_unit;

    typedef struct {
        logic [63:0] exp_res;
        logic        exp_ill;
        string       tag;
        logic [3:0]  op;
        logic        wd;
        logic [63:0] opd;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_i = 4'd0;
    logic        word_i = 1'b0;
    logic [63:0] operand_i = 64'd0;
    logic        en_base_i = 1'b1;
    logic        en_crypto_i = 1'b1;
    logic [63:0] result_o;
    logic        illegal_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    item_t sb[$];

    always #10 clk = ~clk;

    bitcount_byte_unit i_bitcount_byte_unit (
        .op_i(op_i), .word_i(word_i), .operand_i(operand_i),
        .en_base_i(en_base_i), .en_crypto_i(en_crypto_i),
        .result_o(result_o), .illegal_o(illegal_o)
    );

    function automatic logic [63:0] ref_res(logic [3:0] op, logic wd, logic [63:0] a,
                                            logic eb, logic ec, output logic ill);
        logic [63:0] r;
        int n;
        int w;
        bit hit;
        r = 64'd0;
        w = wd ? 32 : 64;
        ill = (op > 4'd7) || (op == 4'd7 ? !(eb || ec) : !eb);
        if (ill) return 64'd0;
        case (op)
            4'd0: begin
                n = 0; hit = 0;
                for (int i = w - 1; i >= 0; i--) begin
                    if (a[i]) hit = 1;
                    if (!hit) n++;
                end
                r = 64'(n);
            end
            4'd1: begin
                n = 0; hit = 0;
                for (int i = 0; i < w; i++) begin
                    if (a[i]) hit = 1;
                    if (!hit) n++;
                end
                r = 64'(n);
            end
            4'd2: begin
                n = 0;
                for (int i = 0; i < w; i++) n += int'(a[i]);
                r = 64'(n);
            end
            4'd3: for (int i = 0; i < 64; i++) r[i] = (i < 8) ? a[i] : a[7];
            4'd4: for (int i = 0; i < 64; i++) r[i] = (i < 16) ? a[i] : a[15];
            4'd5: for (int i = 0; i < 16; i++) r[i] = a[i];
            4'd6: for (int k = 0; k < 8; k++) r[8*k +: 8] = (a[8*k +: 8] != 8'd0) ? 8'hFF : 8'h00;
            default: for (int k = 0; k < 8; k++) r[8*k +: 8] = a[8*(7-k) +: 8];
        endcase
        return r;
    endfunction

    function automatic string tag_of(logic [3:0] op, logic wd, logic ill);
        if (op > 4'd7) return "R11";
        if (ill) return "R10";
        if (op >= 4'd3 && wd) return "R9";
        case (op)
            4'd0: return wd ? "R2" : "R1";
            4'd1: return "R3";
            4'd2: return "R4";
            4'd3, 4'd4: return "R5";
            4'd5: return "R6";
            4'd6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic drive(logic [3:0] op, logic wd, logic [63:0] a, logic eb, logic ec);
        item_t it;
        logic ill;
        @(negedge clk);
        op_i = op; word_i = wd; operand_i = a; en_base_i = eb; en_crypto_i = ec;
        it.exp_res = ref_res(op, wd, a, eb, ec, ill);
        it.exp_ill = ill;
        it.tag = tag_of(op, wd, ill);
        it.op = op; it.wd = wd; it.opd = a;
        sb.push_back(it);
    endtask

    // Monitor: compares at the edge after each drive.
    always @(posedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (result_o !== it.exp_res || illegal_o !== it.exp_ill) begin
                errors++;
                $display("FAIL %s op=%0d word=%0b opd=%h: actual %h/%0b expected %h/%0b",
                         it.tag, it.op, it.wd, it.opd, result_o, illegal_o, it.exp_res, it.exp_ill);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] corners [14];
        corners[0] = 64'd0;                    corners[1] = '1;
        corners[2] = 64'd1;                    corners[3] = 64'h80;
        corners[4] = 64'h8000;                 corners[5] = 64'h8000_0000;
        corners[6] = 64'h1_0000_0000;          corners[7] = 64'h8000_0000_0000_0000;
        corners[8] = 64'hFFFF_FFFF_0000_0000;  corners[9] = 64'h0000_0000_FFFF_FFFF;
        corners[10] = 64'h0123_4567_89AB_CDEF; corners[11] = 64'h00FF_0001_0000_7F00;
        corners[12] = 64'h0000_0080_0000_0000; corners[13] = 64'h7F;

        // Reset state: idle inputs select a full count of zero (R1).
        drive(4'd0, 1'b0, 64'd0, 1'b1, 1'b1);
        repeat (2) @(negedge clk);
        rst = 1'b0;

        // Corner operands over every code and both word settings (R1..R9, R11).
        for (int c = 0; c < 14; c++)
            for (int op = 0; op < 16; op++)
                for (int wd = 0; wd < 2; wd++)
                    drive(4'(op), 1'(wd), corners[c], 1'b1, 1'b0);

        // Enable combinations (R10), including byte reversal under crypto only (R8).
        for (int e = 0; e < 4; e++)
            for (int op = 0; op < 16; op++)
                drive(4'(op), 1'b0, 64'h0102_0304_0506_0708, 1'(e[0]), 1'(e[1]));

        // Random operands (R1..R9).
        for (int n = 0; n < 3000; n++)
            drive(4'($urandom_range(0, 7)), 1'($urandom), {$urandom, $urandom},
                  1'b1, 1'($urandom));

        // Random sparse operands stress the counters (R1, R2, R3).
        for (int n = 0; n < 500; n++)
            drive(4'($urandom_range(0, 2)), 1'($urandom),
                  64'd1 << $urandom_range(0, 63), 1'b1, 1'b0);

        repeat (3) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule